// File: doc/BRIEF.md
# Physical Address Width Adapter

This block sits between a source of internal physical addresses and an external address bus. Each address is 43 bits wide. A configuration bit chooses how many address bits the external bus receives. In wide mode the address crosses unchanged. In narrow mode only the low 41 bits are kept and the top two output bits are driven to zero.

Narrow mode can meet an address whose two dropped bits are not both zero. The block does not hold such an address back. The truncated address still goes out on the bus, and an urgent error bit is raised only after the bus has taken the transfer. That error bit is sticky and stays set until a clear pulse arrives.

Both sides use valid/ready handshakes. One register stage separates them. That stage captures the mode that was in force when a request was accepted, so a later change of the configuration bit does not alter an address that is already waiting on the bus.

Top module: `pa_width_adapter`

## Requirements
- R1: After a synchronous reset, `bus_valid` is 0 and `err_flag` is 0.
- R2: In wide mode (`cfg_narrow` = 0 at acceptance), `bus_addr` equals the accepted `req_addr` in all 43 bits, and that transfer never sets `err_flag`.
- R3: In narrow mode (`cfg_narrow` = 1 at acceptance), `bus_addr[40:0]` equals `req_addr[40:0]` and `bus_addr[42:41]` is 0.
- R4: `req_ready` is high exactly when `bus_valid` is low or `bus_ready` is high. A request accepted on a clock edge shows on the bus from the next cycle with `bus_valid` high.
- R5: While `bus_valid` is high and `bus_ready` is low, the next cycle keeps `bus_valid` high and `bus_addr` unchanged.
- R6: A narrow-mode request with `req_addr[42:41]` nonzero is still transferred on the bus. `err_flag` rises in the cycle after that transfer's handshake completes (`bus_valid` and `bus_ready` both high), and not before.
- R7: `err_flag` stays set until a cycle with `err_clr` high, and it reads 0 from the following cycle. If a new error and `err_clr` come in the same cycle, the error wins and the flag stays set.
- R8: The mode is captured when a request is accepted. Changing `cfg_narrow` while a request waits on the bus changes neither its `bus_addr` nor whether it raises the error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | 1 selects 41-bit external addressing, 0 selects 43-bit |
| req_valid | input | 1 | Request address is valid |
| req_ready | output | 1 | Adapter can accept a request |
| req_addr | input | 43 | Internal physical address |
| bus_valid | output | 1 | External address is valid |
| bus_ready | input | 1 | External bus takes the address |
| bus_addr | output | 43 | External address, top bits zero in narrow mode |
| err_flag | output | 1 | Sticky urgent error for a truncated nonzero upper field |
| err_clr | input | 1 | Pulse to clear `err_flag` |

## Verification
The hardest case to reach from the ports is a bad narrow address that waits on the bus under back-pressure while the mode bit flips. In that case the error must wait for the handshake and must follow the captured mode, not the current one. Long random stretches of low `bus_ready` are mixed with frequent toggles of `cfg_narrow` and with random upper address bits to produce it. Occasional `err_clr` pulses also land in the same cycle as a new error. A behavioural model holds the expected state of the register stage and of the error flag, and it is compared with the outputs on every cycle.

// File: rtl/pa_adapt_pkg.sv
package pa_adapt_pkg;

    localparam int unsigned PA_INT_W    = 43;
    localparam int unsigned PA_NARROW_W = 41;

    typedef enum logic {
        PA_MODE_WIDE   = 1'b0,
        PA_MODE_NARROW = 1'b1
    } pa_mode_e;

    function automatic pa_mode_e mode_of(input logic narrow_bit);
        return narrow_bit ? PA_MODE_NARROW : PA_MODE_WIDE;
    endfunction

endpackage

// File: rtl/pa_mode_xlate.sv
module pa_mode_xlate
    import pa_adapt_pkg::*;
#(
    parameter int unsigned ADDR_W   = PA_INT_W,
    parameter int unsigned NARROW_W = PA_NARROW_W
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  pa_mode_e          mode,
    output logic [ADDR_W-1:0] out_addr,
    output logic              drop_nz
);
    localparam int unsigned DROP_W = ADDR_W - NARROW_W;

    logic [DROP_W-1:0] dropped;

    assign dropped = in_addr[ADDR_W-1:NARROW_W];

    always_comb begin
        out_addr = in_addr;
        drop_nz  = 1'b0;
        if (mode == PA_MODE_NARROW) begin
            out_addr[ADDR_W-1:NARROW_W] = '0;
            drop_nz = |dropped;
        end
    end

endmodule

// File: rtl/pa_out_stage.sv
module pa_out_stage
    import pa_adapt_pkg::*;
#(
    parameter int unsigned ADDR_W   = PA_INT_W,
    parameter int unsigned NARROW_W = PA_NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_bad,
    input  pa_mode_e          in_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_bad,
    output pa_mode_e          out_mode,
    output logic              bad_xfer
);
    logic accept;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign bad_xfer = out_valid && out_ready && out_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_bad   <= 1'b0;
            out_mode  <= PA_MODE_WIDE;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_addr  <= in_addr;
            out_bad   <= in_bad;
            out_mode  <= in_mode;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R4: an accepted request is presented on the next cycle
    p_accept_shows_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R5: a stalled address holds
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_bad));

    // R3: narrow-mode entries carry zero upper bits
    p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_mode == PA_MODE_NARROW |-> out_addr[ADDR_W-1:NARROW_W] == '0);

endmodule

// File: rtl/pa_err_sticky.sv
module pa_err_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_pulse)
            flag <= 1'b1;
        else if (clr_pulse)
            flag <= 1'b0;
    end

    // R7: flag holds without a clear
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
        flag && !clr_pulse |=> flag);

    // R7: a clear alone empties the flag
    p_clear_works_r7: assert property (@(posedge clk) disable iff (rst)
        clr_pulse && !set_pulse |=> !flag);

    // R7: set beats clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> flag);

endmodule

// File: rtl/pa_width_adapter.sv
module pa_width_adapter
    import pa_adapt_pkg::*;
#(
    parameter int unsigned ADDR_W   = PA_INT_W,
    parameter int unsigned NARROW_W = PA_NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_narrow,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              err_flag,
    input  logic              err_clr
);
    pa_mode_e          cur_mode;
    pa_mode_e          held_mode;
    logic [ADDR_W-1:0] xl_addr;
    logic              xl_bad;
    logic              held_bad;
    logic              bad_xfer;

    assign cur_mode = mode_of(cfg_narrow);

    pa_mode_xlate #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_xlate (
        .in_addr (req_addr),
        .mode    (cur_mode),
        .out_addr(xl_addr),
        .drop_nz (xl_bad)
    );

    pa_out_stage #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_addr  (xl_addr),
        .in_bad   (xl_bad),
        .in_mode  (cur_mode),
        .out_valid(bus_valid),
        .out_ready(bus_ready),
        .out_addr (bus_addr),
        .out_bad  (held_bad),
        .out_mode (held_mode),
        .bad_xfer (bad_xfer)
    );

    pa_err_sticky u_err (
        .clk      (clk),
        .rst      (rst),
        .set_pulse(bad_xfer),
        .clr_pulse(err_clr),
        .flag     (err_flag)
    );

    // R6: the error only follows a completed bus handshake
    p_err_after_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(bus_valid && bus_ready));

    // R2: wide-mode entries never carry an error
    p_wide_no_err_r2: assert property (@(posedge clk) disable iff (rst)
        bus_valid && held_mode == PA_MODE_WIDE |-> !held_bad);

    // R8: captured mode does not move while stalled
    p_mode_held_r8: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> $stable(held_mode));

endmodule

// File: tb/pa_width_adapter_test.sv
module pa_width_adapter_test;
    localparam int AW = 43;
    localparam int NW = 41;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_narrow = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          bus_valid;
    logic          bus_ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          err_flag;
    logic          err_clr = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // behavioural reference state
    bit            m_valid = 0;
    bit [AW-1:0]   m_addr  = '0;
    bit            m_bad   = 0;
    bit            m_narrow = 0;
    bit            m_err   = 0;
    bit            m_set_last = 0;
    bit            m_stalled  = 0;

    always #5 clk = ~clk;

    pa_width_adapter uut (
        .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .err_flag(err_flag), .err_clr(err_clr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit set_now;
        bit acc;
        cycles++;
        if (rst) begin
            m_valid = 0; m_err = 0; m_set_last = 0; m_stalled = 0;
        end else begin
            set_now = m_valid && bus_ready && m_bad;
            acc = req_valid && (!m_valid || bus_ready);
            m_stalled = m_valid && !bus_ready;
            if (set_now) m_err = 1;
            else if (err_clr) m_err = 0;
            m_set_last = set_now;
            if (acc) begin
                m_valid  = 1;
                m_narrow = cfg_narrow;
                m_addr   = req_addr;
                m_bad    = 0;
                if (cfg_narrow) begin
                    m_addr[AW-1:NW] = '0;
                    m_bad = (req_addr[AW-1:NW] != 0);
                end
            end else if (bus_ready) begin
                m_valid = 0;
            end
        end
    end

    always @(negedge clk) begin
        string atag;
        if (!rst && !done) begin
            check(bus_valid == m_valid, "R4", "bus_valid", AW'(bus_valid), AW'(m_valid));
            check(req_ready == (!m_valid || bus_ready), "R4", "req_ready",
                  AW'(req_ready), AW'(!m_valid || bus_ready));
            if (m_valid) begin
                if (cfg_narrow != m_narrow) atag = "R8";
                else if (m_stalled)         atag = "R5";
                else if (m_narrow)          atag = "R3";
                else                        atag = "R2";
                check(bus_addr == m_addr, atag, "bus_addr", bus_addr, m_addr);
            end
            check(err_flag == m_err, m_set_last ? "R6" : "R7", "err_flag",
                  AW'(err_flag), AW'(m_err));
        end
    end

    task automatic drive(input bit v, input logic [AW-1:0] a, input bit nar,
                         input bit rdy, input bit clr);
        @(posedge clk); #2;
        req_valid = v; req_addr = a; cfg_narrow = nar; bus_ready = rdy; err_clr = clr;
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        logic [AW-1:0] a;
        a = {$urandom, $urandom};
        return a;
    endfunction

    initial begin
        logic [AW-1:0] bad_a;
        bad_a = {2'b10, 41'h0_1234_5678};
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #3;
        // R1 reset state
        check(bus_valid == 1'b0, "R1", "bus_valid after reset", AW'(bus_valid), '0);
        check(err_flag == 1'b0, "R1", "err_flag after reset", AW'(err_flag), '0);

        // R2 wide pass-through with top bits set
        drive(1, {2'b11, 41'h1_5555_AAAA}, 0, 1, 0);
        drive(0, '0, 0, 1, 0);
        drive(0, '0, 0, 1, 0);
        // R3 narrow, clean address
        drive(1, {2'b00, 41'h0_0F0F_F0F0}, 1, 1, 0);
        drive(0, '0, 1, 1, 0);
        // R6 bad narrow held under back-pressure, R8 mode flip while held
        drive(1, bad_a, 1, 0, 0);
        drive(0, '0, 0, 0, 0);
        drive(0, '0, 0, 0, 0);
        drive(0, '0, 0, 1, 0);
        drive(0, '0, 0, 1, 0);
        drive(0, '0, 0, 1, 0);
        // R7 clear, then set and clear in one cycle
        drive(0, '0, 0, 1, 1);
        drive(0, '0, 0, 1, 0);
        drive(1, bad_a, 1, 1, 0);
        drive(0, '0, 1, 1, 1);
        drive(0, '0, 1, 1, 0);
        drive(0, '0, 1, 1, 1);
        drive(0, '0, 1, 1, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit nar;
            nar = ($urandom_range(0, 3) != 0) ? cfg_narrow : ~cfg_narrow;
            drive($urandom_range(0, 2) != 0, rnd_addr(), nar,
                  $urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0);
        end
        drive(0, '0, 0, 1, 0);
        drive(0, '0, 0, 1, 0);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule